// File: doc/BRIEF.md
# ADC Result Post-Processor

This block sits behind a 16-bit current-measurement converter and works on every conversion result that the converter flags as valid. It has three functions. A decimating result counter raises an interrupt only once every N results. A magnitude comparator holds a sticky flag when a result's absolute value exceeds a programmed threshold. A 32-bit running accumulator lets software form averages. The `twos_mode` pin selects how each result is read: unipolar (unsigned) or two's complement.

Software programs the block through a small register port, with one write strobe, one read strobe and a 3-bit address. A write to the control or mode selector is a reconfiguration event: it restarts the counter and the accumulator. A read of the status word clears the threshold flag. A read of the accumulator clears its ready indication.

Register selectors on `bus_addr`: 0 configuration (bit 0 counter enable, bit 1 accumulator enable), 1 count limit, 2 threshold, 3 result count (read only), 4 accumulator (read only), 5 status (bit 0 threshold flag, bit 1 accumulator ready), 6 control, 7 mode. A write to 6 or 7 is a reconfiguration event, and both read as 0.

Top module: `adc_postproc`

## Requirements
- R1: After reset the configuration, count, threshold and accumulator read 0, the limit reads 1, and `dec_irq`, `thr_flag` and `acc_ready` are 0.
- R2: With configuration bit 0 set, each valid result increments the result count. With bit 0 clear the count holds and no interrupt is raised.
- R3: When the incremented count equals the limit, the count returns to 0 and `dec_irq` is high for exactly the one cycle after the edge that took the result.
- R4: A write to selector 6 or 7 clears the count and the accumulator. In the same cycle as a valid result it takes priority: both end at 0, no interrupt is raised and ready is cleared.
- R5: In unipolar mode `thr_flag` is set by a result whose unsigned 16-bit value is strictly greater than the full 16-bit threshold.
- R6: In two's complement mode the magnitude of the result is compared with threshold bits 14:0 only. The magnitude of 0x8000 saturates to 0x7FFF.
- R7: `thr_flag` is sticky. A read of selector 5 clears it, and a new exceed in the same cycle as that read wins.
- R8: With configuration bit 1 set, each valid result is added to the accumulator modulo 2^32. The result is zero-extended in unipolar mode and sign-extended in two's complement mode. A configuration write with bit 1 clear sets the accumulator to 0.
- R9: `acc_ready` rises in the cycle after an accumulation. It is cleared by a read of selector 4 (an accumulation in the same cycle wins) and by any accumulator clear.
- R10: Reads of selectors 0 to 5 return the registers described above, zero-extended to 32 bits, on the same cycle as the read strobe. A read has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | 16 | Conversion result |
| twos_mode | input | 1 | 1: two's complement coding, 0: unipolar |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register selector |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the selector |
| dec_irq | output | 1 | Decimated interrupt pulse |
| thr_flag | output | 1 | Sticky threshold-exceeded flag |
| acc_ready | output | 1 | Accumulator holds a fresh sum |

## Verification
Every state element takes one edge. A result or register access presented in cycle t shows on `dec_irq`, `thr_flag`, `acc_ready` and in the count and accumulator one edge later, while read data is combinational in cycle t itself. The bench drives inputs on the falling edge and compares `bus_rdata` in the low half of the same cycle, before the edge that applies any side effect of the read. It then advances its reference state and compares the three outputs one time unit after the rising edge. This keeps the reference state exactly one edge behind the inputs, including for collisions such as reconfiguration, read-clear and accumulation landing in the same cycle.

// File: rtl/adc_pp_pkg.sv
package adc_pp_pkg;

  typedef enum logic [2:0] {
    SEL_CFG    = 3'd0,
    SEL_LIMIT  = 3'd1,
    SEL_THRESH = 3'd2,
    SEL_COUNT  = 3'd3,
    SEL_ACC    = 3'd4,
    SEL_STATUS = 3'd5,
    SEL_CTRL   = 3'd6,
    SEL_MODE   = 3'd7
  } reg_sel_e;

  localparam int CFG_CNT_EN_BIT = 0;
  localparam int CFG_ACC_EN_BIT = 1;
  localparam int CFG_W          = 2;

  localparam int STS_THR_BIT = 0;
  localparam int STS_RDY_BIT = 1;

endpackage

// File: rtl/adc_pp_counter.sv
module adc_pp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clear,
  input  logic             strobe,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             irq
);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  logic [CNT_W-1:0] cnt_inc;
  logic             step;
  logic             hit;

  assign cnt_inc = bump(count);
  assign step    = strobe && enable && !clear;
  assign hit     = step && (cnt_inc == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= hit;
      if (clear)     count <= '0;
      else if (hit)  count <= '0;
      else if (step) count <= cnt_inc;
    end
  end

  // R3
  irq_zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == '0));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !clear) |=> $stable(count));

  // R4
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0) && !irq);

endmodule

// File: rtl/adc_pp_thresh.sv
module adc_pp_thresh #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [DATA_W-1:0] data,
  input  logic              tc,
  input  logic [DATA_W-1:0] thresh,
  input  logic              rd_clear,
  output logic              flag
);

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

  function automatic logic [DATA_W-1:0] magnitude(input logic [DATA_W-1:0] d,
                                                  input logic tcm);
    if (!tcm || !d[DATA_W-1]) return d;
    if (d == MOST_NEG)        return MOST_POS;
    return -d;
  endfunction

  function automatic logic exceeds(input logic [DATA_W-1:0] m,
                                   input logic [DATA_W-1:0] t,
                                   input logic tcm);
    if (tcm) return m[DATA_W-2:0] > t[DATA_W-2:0];
    return m > t;
  endfunction

  logic [DATA_W-1:0] mag;
  logic              over;

  assign mag  = magnitude(data, tc);
  assign over = strobe && exceeds(mag, thresh, tc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (over)     flag <= 1'b1;
    else if (rd_clear) flag <= 1'b0;
  end

  // R6
  mag_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && tc) |-> !mag[DATA_W-1]);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !rd_clear) |=> flag);

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over |=> flag);

endmodule

// File: rtl/adc_pp_accum.sv
module adc_pp_accum #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              clear,
  input  logic              strobe,
  input  logic [DATA_W-1:0] data,
  input  logic              tc,
  input  logic              rd_clear,
  output logic [ACC_W-1:0]  acc,
  output logic              ready
);

  localparam int EXT_W = ACC_W - DATA_W;

  function automatic logic [ACC_W-1:0] widen(input logic [DATA_W-1:0] d,
                                             input logic tcm);
    logic fill;
    fill = tcm & d[DATA_W-1];
    return {{EXT_W{fill}}, d};
  endfunction

  logic add_fire;

  assign add_fire = strobe && enable && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      ready <= 1'b0;
    end else if (clear) begin
      acc   <= '0;
      ready <= 1'b0;
    end else if (add_fire) begin
      acc   <= acc + widen(data, tc);
      ready <= 1'b1;
    end else if (rd_clear) begin
      ready <= 1'b0;
    end
  end

  // R9
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(add_fire));

  // R4
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc == '0) && !ready);

  // R8
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!add_fire && !clear) |=> $stable(acc));

endmodule

// File: rtl/adc_postproc.sv
module adc_postproc
  import adc_pp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              twos_mode,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [ACC_W-1:0]  bus_wdata,
  output logic [ACC_W-1:0]  bus_rdata,
  output logic              dec_irq,
  output logic              thr_flag,
  output logic              acc_ready
);

  localparam logic [CNT_W-1:0] LIMIT_RST = {{(CNT_W-1){1'b0}}, 1'b1};

  reg_sel_e          sel;
  logic [CFG_W-1:0]  cfg_q;
  logic [CNT_W-1:0]  limit_q;
  logic [DATA_W-1:0] thresh_q;
  logic [CNT_W-1:0]  count;
  logic [ACC_W-1:0]  acc;

  logic reconf;
  logic cfg_wr;
  logic acc_clr;
  logic sts_rd;
  logic acc_rd;

  assign sel     = reg_sel_e'(bus_addr);
  assign reconf  = bus_wr && (sel == SEL_CTRL || sel == SEL_MODE);
  assign cfg_wr  = bus_wr && (sel == SEL_CFG);
  assign acc_clr = reconf || (cfg_wr && !bus_wdata[CFG_ACC_EN_BIT]);
  assign sts_rd  = bus_rd && (sel == SEL_STATUS);
  assign acc_rd  = bus_rd && (sel == SEL_ACC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      limit_q  <= LIMIT_RST;
      thresh_q <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_CFG:    cfg_q    <= bus_wdata[CFG_W-1:0];
        SEL_LIMIT:  limit_q  <= bus_wdata[CNT_W-1:0];
        SEL_THRESH: thresh_q <= bus_wdata[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_CFG:    bus_rdata[CFG_W-1:0]  = cfg_q;
      SEL_LIMIT:  bus_rdata[CNT_W-1:0]  = limit_q;
      SEL_THRESH: bus_rdata[DATA_W-1:0] = thresh_q;
      SEL_COUNT:  bus_rdata[CNT_W-1:0]  = count;
      SEL_ACC:    bus_rdata             = acc;
      SEL_STATUS: begin
        bus_rdata[STS_THR_BIT] = thr_flag;
        bus_rdata[STS_RDY_BIT] = acc_ready;
      end
      default:    bus_rdata = '0;
    endcase
  end

  adc_pp_counter #(.CNT_W(CNT_W)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (cfg_q[CFG_CNT_EN_BIT]),
    .clear  (reconf),
    .strobe (res_valid),
    .limit  (limit_q),
    .count  (count),
    .irq    (dec_irq)
  );

  adc_pp_thresh #(.DATA_W(DATA_W)) u_thresh (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (res_valid),
    .data     (res_data),
    .tc       (twos_mode),
    .thresh   (thresh_q),
    .rd_clear (sts_rd),
    .flag     (thr_flag)
  );

  adc_pp_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (cfg_q[CFG_ACC_EN_BIT]),
    .clear    (acc_clr),
    .strobe   (res_valid),
    .data     (res_data),
    .tc       (twos_mode),
    .rd_clear (acc_rd),
    .acc      (acc),
    .ready    (acc_ready)
  );

  // R4
  reconf_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reconf |=> !dec_irq && (count == '0) && (acc == '0));

  // R10
  count_read_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !res_valid) |=> $stable(count));

endmodule

// File: tb/adc_postproc_test.sv
module adc_postproc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [15:0] res_data = '0;
  logic        twos_mode = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dec_irq, thr_flag, acc_ready;

  int vectors = 0;
  int miscompares = 0;

  // reference state
  logic [1:0]  m_cfg;
  logic [15:0] m_limit, m_thr, m_cnt;
  logic [31:0] m_acc;
  logic        m_irq, m_flag, m_rdy;

  always #10 clk = ~clk;

  adc_postproc uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .twos_mode(twos_mode), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dec_irq(dec_irq), .thr_flag(thr_flag), .acc_ready(acc_ready)
  );

  function automatic bit over_thr(input logic [15:0] d, input logic tc,
                                  input logic [15:0] t);
    int v, lim;
    if (!tc) return int'(d) > int'(t);
    v = int'($signed(d));
    if (v < 0) v = -v;
    if (v > 32767) v = 32767;
    lim = int'(t) % 32768;
    return v > lim;
  endfunction

  function automatic logic [31:0] read_model(input logic [2:0] a);
    case (a)
      3'd0: return {30'd0, m_cfg};
      3'd1: return {16'd0, m_limit};
      3'd2: return {16'd0, m_thr};
      3'd3: return {16'd0, m_cnt};
      3'd4: return m_acc;
      3'd5: return {30'd0, m_rdy, m_flag};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [15:0] d, input logic tc,
                       input logic wr, input logic rd, input logic [2:0] a,
                       input logic [31:0] wd, input string tag);
    logic        recfg, aclr, addf, step, n_irq;
    logic [15:0] inc;
    @(negedge clk);
    res_valid = v; res_data = d; twos_mode = tc;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    #5;
    if (rd) check(tag, bus_rdata, read_model(a));
    recfg = wr && (a == 3'd6 || a == 3'd7);
    aclr  = recfg || (wr && a == 3'd0 && !wd[1]);
    addf  = v && m_cfg[1] && !aclr;
    step  = v && m_cfg[0] && !recfg;
    inc   = m_cnt + 16'd1;
    n_irq = step && (inc == m_limit);
    if (v && over_thr(d, tc, m_thr)) m_flag = 1'b1;
    else if (rd && a == 3'd5)        m_flag = 1'b0;
    if (aclr) begin
      m_acc = 32'd0; m_rdy = 1'b0;
    end else if (addf) begin
      m_acc = m_acc + (tc ? 32'($signed(d)) : {16'd0, d});
      m_rdy = 1'b1;
    end else if (rd && a == 3'd4) m_rdy = 1'b0;
    if (recfg)       m_cnt = 16'd0;
    else if (n_irq)  m_cnt = 16'd0;
    else if (step)   m_cnt = inc;
    m_irq = n_irq;
    if (wr && a == 3'd0) m_cfg = wd[1:0];
    if (wr && a == 3'd1) m_limit = wd[15:0];
    if (wr && a == 3'd2) m_thr = wd[15:0];
    @(posedge clk);
    #1;
    check("R3 irq", {31'd0, dec_irq}, {31'd0, m_irq});
    check("R7 flag", {31'd0, thr_flag}, {31'd0, m_flag});
    check("R9 ready", {31'd0, acc_ready}, {31'd0, m_rdy});
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] wd);
    apply(1'b0, 16'd0, 1'b0, 1'b1, 1'b0, a, wd, "R10");
  endtask

  task automatic rreg(input logic [2:0] a, input string tag);
    apply(1'b0, 16'd0, 1'b0, 1'b0, 1'b1, a, 32'd0, tag);
  endtask

  task automatic sample(input logic [15:0] d, input logic tc);
    apply(1'b1, d, tc, 1'b0, 1'b0, 3'd0, 32'd0, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run incomplete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    m_cfg = 2'd0; m_limit = 16'd1; m_thr = 16'd0; m_cnt = 16'd0;
    m_acc = 32'd0; m_irq = 1'b0; m_flag = 1'b0; m_rdy = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq", {31'd0, dec_irq}, 32'd0);
    check("R1 flag", {31'd0, thr_flag}, 32'd0);
    check("R1 ready", {31'd0, acc_ready}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rreg(3'(a), "R1");

    // R2: counter disabled holds
    sample(16'h0005, 1'b0);
    rreg(3'd3, "R2");
    // R3: limit 3 decimation
    wreg(3'd1, 32'd3);
    wreg(3'd0, 32'd3);
    for (int i = 0; i < 7; i++) begin
      sample(16'h0010, 1'b0);
      rreg(3'd3, "R3");
    end
    // R8: sign extension and unipolar zero extension
    sample(16'hFFFF, 1'b1);
    rreg(3'd4, "R8");
    sample(16'hFFFF, 1'b0);
    rreg(3'd4, "R8");
    // R4: reconfig colliding with a result
    apply(1'b1, 16'h0100, 1'b0, 1'b1, 1'b0, 3'd6, 32'd0, "R4");
    rreg(3'd3, "R4");
    rreg(3'd4, "R4");
    sample(16'h0001, 1'b0);
    sample(16'h0001, 1'b0);
    apply(1'b1, 16'h0100, 1'b0, 1'b1, 1'b0, 3'd7, 32'd0, "R4");
    rreg(3'd3, "R4");
    // R8: disabling the accumulator clears it
    sample(16'h0042, 1'b0);
    wreg(3'd0, 32'd1);
    rreg(3'd4, "R8");
    wreg(3'd0, 32'd3);
    // R5 / R6 threshold corners
    rreg(3'd5, "R7");
    wreg(3'd2, 32'h0000_7FFF);
    sample(16'h8000, 1'b0);
    rreg(3'd5, "R5");
    rreg(3'd5, "R5");
    wreg(3'd2, 32'h0000_FFFF);
    sample(16'h8000, 1'b1);
    rreg(3'd5, "R6");
    wreg(3'd2, 32'h0000_7FFE);
    sample(16'h8000, 1'b1);
    rreg(3'd5, "R6");
    // R7: exceed wins over read-clear
    apply(1'b1, 16'h8000, 1'b1, 1'b0, 1'b1, 3'd5, 32'd0, "R7");
    rreg(3'd5, "R7");
    // R9: accumulation wins over read-clear of ready
    apply(1'b1, 16'h0003, 1'b0, 1'b0, 1'b1, 3'd4, 32'd0, "R9");
    rreg(3'd4, "R9");
    rreg(3'd5, "R9");

    // random phase
    wreg(3'd1, 32'd4);
    for (int i = 0; i < 4000; i++) begin
      logic [2:0]  a;
      logic        wr, rd;
      logic [31:0] wd;
      int          pick;
      pick = int'($urandom_range(0, 99));
      wr = 1'b0; rd = 1'b1; a = 3'd3; wd = 32'd0;
      if (pick < 4)       begin wr = 1'b1; rd = 1'b0; a = 3'($urandom_range(6, 7)); end
      else if (pick < 6)  begin wr = 1'b1; rd = 1'b0; a = 3'd0; wd = 32'($urandom_range(0, 3)); end
      else if (pick < 8)  begin wr = 1'b1; rd = 1'b0; a = 3'd1; wd = 32'($urandom_range(0, 9)); end
      else if (pick < 10) begin wr = 1'b1; rd = 1'b0; a = 3'd2; wd = $urandom; end
      else if (pick < 20) a = 3'd4;
      else if (pick < 30) a = 3'd5;
      apply(1'($urandom_range(0, 1)), 16'($urandom), 1'($urandom_range(0, 1)),
            wr, rd, a, wd, (a == 3'd4) ? "R8" : (a == 3'd5) ? "R7" : "R2");
    end

    apply(1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0, "R10");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule